// File: doc/BRIEF.md
# Half-Cycle Time-Shared Register File

This block is a processor register file with one write port and two read ports, built only from single-port storage arrays. Each clock cycle is split into two halves. While the clock is low, the arrays are addressed by the destination register, and the rising edge commits the result. While the clock is high, the same arrays are addressed by a source register, and the falling edge latches the selected word into an operand register. Because one single-port array can serve only one read address per cycle, the storage is kept in two identical copies. Both copies take every write, and each copy feeds one read port.

A 32-entry configuration is assembled from two 16-entry banks. The top address bit routes the write enable to one bank only and steers a 2-to-1 read multiplexer. A 16-entry configuration uses a single bank per copy. Word width is a parameter. The register count is a parameter restricted to 16 or 32. The storage is not reset. The two operand registers clear synchronously.

Top module: `hc_regfile`

## Requirements
- R1: When `wr_en` is 1 at a rising edge of `clk`, both storage copies take `wr_data` at entry `wr_addr`.
- R2: At each falling edge of `clk` with `rst` at 0, `op_a` takes the stored word at `rd_addr_a`, and `op_b` takes the stored word at `rd_addr_b`.
- R3: A word written at a rising edge is the value captured at the very next falling edge by any read port that addresses the same entry.
- R4: The two read ports are independent: each can address any entry in the same cycle, and equal addresses give equal operands.
- R5: When `wr_en` is 0 at a rising edge, no entry changes, and read capture at the next falling edge continues as usual.
- R6: With 32 entries, address bit 4 selects the bank. Entries that differ only in bit 4 (for example 3 and 19) hold separate words, and writing one leaves the other unchanged.
- R7: `rst` is active high and is sampled at falling edges. When it is 1, both operand outputs become zero at that falling edge. The stored words survive the reset.
- R8: Every entry, including entry 0 and the highest entry, is writable and reads back what was written.
- R9: The operand outputs change only at falling edges. Across a rising edge they hold their values, even when that edge writes the entry being read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The rising edge writes; the falling edge captures operands |
| rst | input | 1 | Synchronous active-high clear of the operand registers |
| wr_en | input | 1 | Write enable for the destination register |
| wr_addr | input | AW | Destination register index |
| wr_data | input | DATA_W | Result word to store |
| rd_addr_a | input | AW | Source register index for port A |
| rd_addr_b | input | AW | Source register index for port B |
| op_a | output | DATA_W | Registered operand from port A |
| op_b | output | DATA_W | Registered operand from port B |

## Verification
The assertions assume that every input changes only shortly after a falling edge and then holds through the following rising and falling edges. Under that assumption, the write fields seen at a falling edge are exactly those committed at the rising edge just before it. The bench follows this by driving each new input set half a nanosecond after a falling edge. It never changes an input mid-cycle. It writes every entry before the random phase begins, so no read ever returns an unwritten word.

// File: rtl/hcrf_pkg.sv
package hcrf_pkg;
    localparam int unsigned BANK_ENTRIES = 16;
    localparam int unsigned BANK_AW      = $clog2(BANK_ENTRIES);

    function automatic bit legal_count(input int unsigned n);
        return (n == 16) || (n == 32);
    endfunction
endpackage

// File: rtl/hcrf_bank.sv
module hcrf_bank #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [hcrf_pkg::BANK_AW-1:0] waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [hcrf_pkg::BANK_AW-1:0] raddr,
    output logic [DATA_W-1:0]           rdata
);
    import hcrf_pkg::*;

    // Low phase presents waddr (committed at the rising edge); high phase
    // presents raddr (sampled by the capture flops at the falling edge).
    logic [DATA_W-1:0] cells_q [BANK_ENTRIES];

    always_ff @(posedge clk) begin
        if (we) cells_q[waddr] <= wdata;
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/hcrf_copy.sv
module hcrf_copy #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 32,
    localparam int unsigned AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    import hcrf_pkg::*;

    localparam int unsigned NBANK = NUM_REGS / BANK_ENTRIES;

    if (NBANK == 2) begin : g_split
        logic [DATA_W-1:0] bank_rd [2];
        for (genvar k = 0; k < 2; k++) begin : g_bank
            logic bank_we;
            assign bank_we = we && (waddr[AW-1] == 1'(k));
            hcrf_bank #(.DATA_W(DATA_W)) u_bank (
                .clk  (clk),
                .we   (bank_we),
                .waddr(waddr[BANK_AW-1:0]),
                .wdata(wdata),
                .raddr(raddr[BANK_AW-1:0]),
                .rdata(bank_rd[k])
            );
        end
        assign rdata = raddr[AW-1] ? bank_rd[1] : bank_rd[0];
    end else begin : g_single
        hcrf_bank #(.DATA_W(DATA_W)) u_bank (
            .clk  (clk),
            .we   (we),
            .waddr(waddr[BANK_AW-1:0]),
            .wdata(wdata),
            .raddr(raddr[BANK_AW-1:0]),
            .rdata(rdata)
        );
    end
endmodule

// File: rtl/hc_regfile.sv
module hc_regfile #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 32,
    localparam int unsigned AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr_a,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b
);
    localparam int unsigned NPORT = 2;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } capt_t;

    logic [AW-1:0]     port_raddr [NPORT];
    logic [DATA_W-1:0] port_rdata [NPORT];

    assign port_raddr[0] = rd_addr_a;
    assign port_raddr[1] = rd_addr_b;

    // One full storage copy per read port; all copies see the same write.
    for (genvar p = 0; p < NPORT; p++) begin : g_copy
        hcrf_copy #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_copy (
            .clk  (clk),
            .we   (wr_en),
            .waddr(wr_addr),
            .wdata(wr_data),
            .raddr(port_raddr[p]),
            .rdata(port_rdata[p])
        );
    end

    capt_t capt_d, capt_q;

    always_comb begin
        capt_d = capt_q;
        if (rst) begin
            capt_d = '0;
        end else begin
            capt_d.a = port_rdata[0];
            capt_d.b = port_rdata[1];
        end
    end

    always_ff @(negedge clk) begin
        capt_q <= capt_d;
    end

    assign op_a = capt_q.a;
    assign op_b = capt_q.b;
endmodule

// File: rtl/hcrf_checker.sv
module hcrf_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AW     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [AW-1:0]     rd_addr_a,
    input logic [AW-1:0]     rd_addr_b,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b
);
    assert_reset_clears_R7: assert property (@(negedge clk)
        rst |=> (op_a == '0 && op_b == '0));

    assert_write_then_read_R3: assert property (@(negedge clk) disable iff (rst)
        (wr_en && wr_addr == rd_addr_a) |=> (op_a == $past(wr_data)));

    assert_ports_agree_R4: assert property (@(negedge clk) disable iff (rst)
        (rd_addr_a == rd_addr_b) |=> (op_a == op_b));

    assert_idle_keeps_R5: assert property (@(negedge clk) disable iff (rst)
        (!wr_en && !$past(rst) && rd_addr_b == $past(rd_addr_b)) |=> $stable(op_b));
endmodule

bind hc_regfile hcrf_checker #(.DATA_W(DATA_W), .AW(AW)) u_hcrf_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .op_a(op_a), .op_b(op_b)
);

// File: tb/hc_regfile_test.sv
`timescale 1ns/100ps
module hc_regfile_test;
    localparam int unsigned DW = 32;
    localparam int unsigned NR = 32;
    localparam int unsigned AW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr_a = '0;
    logic [AW-1:0] rd_addr_b = '0;
    logic [DW-1:0] op_a, op_b;

    int            n_tests = 0;
    int            n_fail  = 0;
    bit            done    = 0;
    logic [DW-1:0] mdl [NR];
    logic [DW-1:0] last_a = '0, last_b = '0;

    always #2 clk = ~clk;

    hc_regfile #(.DATA_W(DW), .NUM_REGS(NR)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .op_a(op_a), .op_b(op_b)
    );

    function automatic logic [DW-1:0] pattern(input int unsigned i);
        return 32'hA5C3_0000 ^ (i * 32'h0101_1357);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs just after a falling edge, then check across
    // the rising edge (hold) and after the capturing falling edge.
    task automatic step(input bit we, input int unsigned wa, input logic [DW-1:0] wd,
                        input int unsigned ra, input int unsigned rb, input string req);
        logic [DW-1:0] ea, eb;
        wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        rd_addr_a = AW'(ra); rd_addr_b = AW'(rb);
        if (we) mdl[wa] = wd;
        ea = mdl[ra];
        eb = mdl[rb];
        @(posedge clk); #0.5;
        check("R9 hold A", op_a, last_a);
        check("R9 hold B", op_b, last_b);
        @(negedge clk); #0.5;
        check({req, " A"}, op_a, ea);
        check({req, " B"}, op_b, eb);
        last_a = ea;
        last_b = eb;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        #0.5;
        check("R7 reset A", op_a, '0);
        check("R7 reset B", op_b, '0);
        rst = 1'b0;

        // R8 / R1: fill every entry, reading it back on both ports at once (R3)
        for (int i = 0; i < int'(NR); i++) step(1, i, pattern(i), i, i, "R8 fill");
        step(0, 0, '0, 0, NR - 1, "R8 ends");

        // R6: entries 3 and 19 share low bits but live in separate banks
        step(1, 3, 32'h1111_2222, 19, 3, "R6 bank lo");
        step(1, 19, 32'h3333_4444, 3, 19, "R6 bank hi");

        // R5: disabled write must leave the entry alone
        step(0, 7, 32'hDEAD_BEEF, 7, 7, "R5 no write");
        step(0, 7, 32'hFFFF_FFFF, 6, 7, "R5 idle read");

        // R4: independent ports on distinct entries
        step(0, 0, '0, 12, 28, "R4 distinct");

        // R7: reset clears outputs, storage survives
        wr_en = 1'b0; rst = 1'b1;
        @(negedge clk); #0.5;
        check("R7 clear A", op_a, '0);
        check("R7 clear B", op_b, '0);
        rst = 1'b0; last_a = '0; last_b = '0;
        step(0, 0, '0, 3, 19, "R7 retained");

        // R2 / R3 random mix, frequent same-entry write-then-read
        for (int n = 0; n < 3000; n++) begin
            int unsigned wa, ra, rb;
            bit we;
            wa = $urandom_range(NR - 1);
            ra = $urandom_range(NR - 1);
            rb = $urandom_range(NR - 1);
            we = ($urandom_range(3) != 0);
            if ($urandom_range(3) == 0) ra = wa;
            if ($urandom_range(4) == 0) rb = wa;
            step(we, wa, $urandom(), ra, rb, "R2 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule